// File: doc/BRIEF.md
# Register Rename Unit with Zero-Idiom Handling

This block translates architectural register names into physical register tags, one instruction per cycle. It holds a speculative name-to-tag map, a first-in first-out list of unused physical tags, and one ready bit per physical register. An instruction that writes a destination takes the tag at the head of the free list. Later readers of that name see the new tag, so a write-only destination cuts the chain to the older value even when the older producers have not executed yet. The tag that the destination held before is reported alongside the new one. It goes back to the free list only when that instruction retires, and retirement happens in program order.

Two instruction classes get special treatment. A self-zeroing idiom, such as an exclusive-or of a register with itself, has a result that is known at rename time. Its new tag is marked ready when it is allocated, and the idiom reports no source operands. A bit-count-class instruction (population count, leading-zero count, trailing-zero count) can optionally be given a false read of its destination, selected by a configuration pin. When that option is on, the old destination tag appears as an extra source, and the dependency chain is kept rather than broken.

The block is controlled by a two-state machine. In `ST_ACTIVE` it accepts rename requests. In `ST_STARVED` the free list is empty and nothing is accepted. The transition *exhaust* goes from `ST_ACTIVE` to `ST_STARVED`: it fires when an allocation takes the last free tag and no tag is returned in the same cycle. The transition *replenish* goes from `ST_STARVED` to `ST_ACTIVE`: it fires when a retirement returns a tag. In every other case the machine holds its state.

Top module: `rr_rename_unit`

## Requirements
- R1: After reset, architectural name i maps to physical tag i and is ready. Tags 16 to 179 are free and not ready, and the free list hands them out in ascending order.
- R2: An accepted instruction with a destination receives the tag at the head of the free list as `out_dst_tag`. `out_old_tag` is the tag the destination name held before. From the next cycle on, reads of that name return the new tag, and the new tag always differs from the old one.
- R3: A newly allocated tag is not ready unless the instruction is a zero idiom. A writeback of a tag makes it ready for every later read.
- R4: A read-modify-write destination (`in_rmw`=1) reports the current mapping of the destination as source 2. Its tag equals `out_old_tag`.
- R5: A zero idiom (`in_zero_idiom`=1) reports no valid source, and its new tag is reported ready at rename (`out_dst_rdy`=1).
- R6: With `cfg_bitcnt_dep`=1, a bit-count instruction (`in_bitcount`=1) reports its old destination tag as source 2 even if it is write-only. With `cfg_bitcnt_dep`=0, it reports no source 2.
- R7: A retirement with `ret_old_vld`=1 appends `ret_old_tag` to the tail of the free list. Tags are reallocated in the order they were returned.
- R8: If a writeback hits a tag in the same cycle that a rename reads it, the rename reports that source as ready.
- R9: When a source name equals the destination name, the source gets the mapping from before the update.
- R10: With an empty free list, `in_ready`=0 and a presented instruction changes no state. A tag freed in a cycle makes `in_ready`=1 from the next cycle, and that tag is the next one allocated.
- R11: An instruction without a destination allocates nothing (`out_dst_vld`=0). A retirement with `ret_old_vld`=0 frees nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bitcnt_dep | input | 1 | Enable the false destination read for bit-count instructions |
| in_valid | input | 1 | Rename request present |
| in_ready | output | 1 | Request accepted this cycle (state `ST_ACTIVE`) |
| in_src0_vld | input | 1 | Source 0 used |
| in_src0 | input | 4 | Source 0 architectural name |
| in_src1_vld | input | 1 | Source 1 used |
| in_src1 | input | 4 | Source 1 architectural name |
| in_dst_vld | input | 1 | Destination written |
| in_dst | input | 4 | Destination architectural name |
| in_rmw | input | 1 | Destination is read as well as written |
| in_zero_idiom | input | 1 | Self-zeroing instruction |
| in_bitcount | input | 1 | Bit-count-class instruction |
| out_valid | output | 1 | Rename result valid (request accepted) |
| out_src0_vld | output | 1 | Source 0 dependency present |
| out_src0_tag | output | 8 | Source 0 physical tag |
| out_src0_rdy | output | 1 | Source 0 value ready |
| out_src1_vld | output | 1 | Source 1 dependency present |
| out_src1_tag | output | 8 | Source 1 physical tag |
| out_src1_rdy | output | 1 | Source 1 value ready |
| out_src2_vld | output | 1 | Destination-as-source dependency present |
| out_src2_tag | output | 8 | Old destination tag read as a source |
| out_src2_rdy | output | 1 | That source is ready |
| out_dst_vld | output | 1 | A new tag was allocated |
| out_dst_tag | output | 8 | Newly allocated physical tag |
| out_dst_rdy | output | 1 | New tag ready at allocation |
| out_old_tag | output | 8 | Previous tag of the destination, freed at retirement |
| ret_valid | input | 1 | An instruction retires |
| ret_old_vld | input | 1 | The retiring instruction has a tag to free |
| ret_old_tag | input | 8 | Tag returned to the free list |
| wb_valid | input | 1 | A result is written back |
| wb_tag | input | 8 | Tag whose ready bit is set |

## Verification
The hardest situation to reach from the ports is the starved state. It needs all 164 free tags to be allocated while none is retired, and then a retirement and a rename request in the very same cycle. The stimulus allocates destinations until the bench's own free-list model is empty. It then presents an instruction that must be refused, next presents one together with a retirement that must still be refused, and finally checks that the following request is accepted and receives exactly the tag that was just returned. The earlier sweep crosses the read-modify-write, zero-idiom, bit-count and option settings with same-name sources, same-cycle writebacks and interleaved retirements, so that the bypass and the lookup-before-update ordering are exercised.

// File: rtl/rr_pkg.sv
package rr_pkg;
    localparam int RR_NUM_ARCH = 16;
    localparam int RR_NUM_PHYS = 180;

    typedef enum logic {
        ST_ACTIVE  = 1'b0,
        ST_STARVED = 1'b1
    } rr_state_e;
endpackage

// File: rtl/rr_map_table.sv
module rr_map_table #(
    parameter int NUM_ARCH = 16,
    parameter int TAG_W    = 8,
    parameter int NRD      = 3,
    localparam int ARCH_W  = $clog2(NUM_ARCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ARCH_W-1:0] rd_name [NRD],
    output logic [TAG_W-1:0]  rd_tag  [NRD],
    input  logic              wr_en,
    input  logic [ARCH_W-1:0] wr_name,
    input  logic [TAG_W-1:0]  wr_tag
);
    logic [TAG_W-1:0] map_q [NUM_ARCH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                map_q[i] <= TAG_W'(i);
            end
        end else if (wr_en) begin
            map_q[wr_name] <= wr_tag;
        end
    end

    // Reads see the table before this cycle's update.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_tag[g] = map_q[rd_name[g]];
    end
endmodule

// File: rtl/rr_free_list.sv
module rr_free_list #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 180,
    parameter int TAG_W    = 8,
    localparam int DEPTH   = NUM_PHYS - NUM_ARCH,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    output logic [TAG_W-1:0] head_tag,
    output logic [CNT_W-1:0] count
);
    logic [TAG_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= TAG_W'(NUM_ARCH + i);
            end
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= CNT_W'(DEPTH);
        end else begin
            if (push) begin
                slot_q[wr_ptr_q] <= push_tag;
                wr_ptr_q         <= ptr_inc(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= ptr_inc(rd_ptr_q);
            end
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head_tag = slot_q[rd_ptr_q];
    assign count    = cnt_q;
endmodule

// File: rtl/rr_ready_table.sv
module rr_ready_table #(
    parameter int NUM_ARCH = 16,
    parameter int NUM_PHYS = 180,
    parameter int TAG_W    = 8,
    parameter int NRD      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic             wb_en,
    input  logic [TAG_W-1:0] wb_tag,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             alloc_val,
    input  logic [TAG_W-1:0] rd_tag [NRD],
    output logic             rd_rdy [NRD]
);
    logic [NUM_PHYS-1:0] rdy_q;

    // Later statements take priority: free clears, writeback sets,
    // allocation decides the initial state of a fresh tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                rdy_q[i] <= (i < NUM_ARCH);
            end
        end else begin
            if (clr_en)   rdy_q[clr_tag]   <= 1'b0;
            if (wb_en)    rdy_q[wb_tag]    <= 1'b1;
            if (alloc_en) rdy_q[alloc_tag] <= alloc_val;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_rdy[g] = rdy_q[rd_tag[g]] | (wb_en && (wb_tag == rd_tag[g]));
    end
endmodule

// File: rtl/rr_rename_unit.sv
module rr_rename_unit
    import rr_pkg::*;
#(
    parameter int NUM_ARCH = RR_NUM_ARCH,
    parameter int NUM_PHYS = RR_NUM_PHYS,
    localparam int TAG_W   = $clog2(NUM_PHYS),
    localparam int ARCH_W  = $clog2(NUM_ARCH),
    localparam int DEPTH   = NUM_PHYS - NUM_ARCH,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int NRD     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bitcnt_dep,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_src0_vld,
    input  logic [ARCH_W-1:0] in_src0,
    input  logic              in_src1_vld,
    input  logic [ARCH_W-1:0] in_src1,
    input  logic              in_dst_vld,
    input  logic [ARCH_W-1:0] in_dst,
    input  logic              in_rmw,
    input  logic              in_zero_idiom,
    input  logic              in_bitcount,
    output logic              out_valid,
    output logic              out_src0_vld,
    output logic [TAG_W-1:0]  out_src0_tag,
    output logic              out_src0_rdy,
    output logic              out_src1_vld,
    output logic [TAG_W-1:0]  out_src1_tag,
    output logic              out_src1_rdy,
    output logic              out_src2_vld,
    output logic [TAG_W-1:0]  out_src2_tag,
    output logic              out_src2_rdy,
    output logic              out_dst_vld,
    output logic [TAG_W-1:0]  out_dst_tag,
    output logic              out_dst_rdy,
    output logic [TAG_W-1:0]  out_old_tag,
    input  logic              ret_valid,
    input  logic              ret_old_vld,
    input  logic [TAG_W-1:0]  ret_old_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag
);
    rr_state_e         state_q, state_d;
    logic              fire, alloc, ret_push;
    logic [TAG_W-1:0]  head_tag;
    logic [CNT_W-1:0]  free_cnt;
    logic [ARCH_W-1:0] map_rd_name [NRD];
    logic [TAG_W-1:0]  map_rd_tag  [NRD];
    logic              tag_rdy     [NRD];
    logic              dst_as_src;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                // exhaust: the last free tag is taken and none comes back
                if (alloc && !ret_push && (free_cnt == CNT_W'(1))) state_d = ST_STARVED;
            end
            ST_STARVED: begin
                // replenish: a retirement returns a tag
                if (ret_push) state_d = ST_ACTIVE;
            end
        endcase
    end

    // ---------------- outputs of the state machine ----------------
    always_comb begin
        in_ready = 1'b0;
        unique case (state_q)
            ST_ACTIVE:  in_ready = 1'b1;
            ST_STARVED: in_ready = 1'b0;
        endcase
    end

    assign fire     = in_valid && in_ready;
    assign alloc    = fire && in_dst_vld;
    assign ret_push = ret_valid && ret_old_vld;

    // ---------------- map lookups (before update) ----------------
    assign map_rd_name[0] = in_src0;
    assign map_rd_name[1] = in_src1;
    assign map_rd_name[2] = in_dst;

    rr_map_table #(
        .NUM_ARCH (NUM_ARCH),
        .TAG_W    (TAG_W),
        .NRD      (NRD)
    ) i_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_name (map_rd_name),
        .rd_tag  (map_rd_tag),
        .wr_en   (alloc),
        .wr_name (in_dst),
        .wr_tag  (head_tag)
    );

    rr_free_list #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS),
        .TAG_W    (TAG_W)
    ) i_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop      (alloc),
        .push     (ret_push),
        .push_tag (ret_old_tag),
        .head_tag (head_tag),
        .count    (free_cnt)
    );

    rr_ready_table #(
        .NUM_ARCH (NUM_ARCH),
        .NUM_PHYS (NUM_PHYS),
        .TAG_W    (TAG_W),
        .NRD      (NRD)
    ) i_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_en    (ret_push),
        .clr_tag   (ret_old_tag),
        .wb_en     (wb_valid),
        .wb_tag    (wb_tag),
        .alloc_en  (alloc),
        .alloc_tag (head_tag),
        .alloc_val (in_zero_idiom),
        .rd_tag    (map_rd_tag),
        .rd_rdy    (tag_rdy)
    );

    // ---------------- operand decode ----------------
    assign dst_as_src = in_dst_vld && !in_zero_idiom &&
                        (in_rmw || (cfg_bitcnt_dep && in_bitcount));

    assign out_valid    = fire;
    assign out_src0_vld = fire && in_src0_vld && !in_zero_idiom;
    assign out_src0_tag = map_rd_tag[0];
    assign out_src0_rdy = tag_rdy[0];
    assign out_src1_vld = fire && in_src1_vld && !in_zero_idiom;
    assign out_src1_tag = map_rd_tag[1];
    assign out_src1_rdy = tag_rdy[1];
    assign out_src2_vld = fire && dst_as_src;
    assign out_src2_tag = map_rd_tag[2];
    assign out_src2_rdy = tag_rdy[2];
    assign out_dst_vld  = alloc;
    assign out_dst_tag  = head_tag;
    assign out_dst_rdy  = in_zero_idiom;
    assign out_old_tag  = map_rd_tag[2];
endmodule

// File: rtl/rr_rename_checker.sv
module rr_rename_checker #(
    parameter int TAG_W = 8,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             in_rmw,
    input logic             in_zero_idiom,
    input logic             in_dst_vld,
    input logic             out_valid,
    input logic             out_src0_vld,
    input logic [TAG_W-1:0] out_src0_tag,
    input logic             out_src0_rdy,
    input logic             out_src1_vld,
    input logic             out_src2_vld,
    input logic [TAG_W-1:0] out_src2_tag,
    input logic             out_dst_vld,
    input logic [TAG_W-1:0] out_dst_tag,
    input logic             out_dst_rdy,
    input logic [TAG_W-1:0] out_old_tag,
    input logic             ret_valid,
    input logic             ret_old_vld,
    input logic             wb_valid,
    input logic [TAG_W-1:0] wb_tag,
    input logic [CNT_W-1:0] free_cnt
);
    AST_EMPTY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0) |-> !in_ready); // R10

    AST_FREED_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((free_cnt == '0) && ret_valid && ret_old_vld) |=> in_ready); // R10

    AST_ZERO_IDIOM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_zero_idiom && out_dst_vld) |->
        (out_dst_rdy && !out_src0_vld && !out_src1_vld && !out_src2_vld)); // R5

    AST_FRESH_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dst_vld && !in_zero_idiom) |-> !out_dst_rdy); // R3

    AST_RMW_OLD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_dst_vld && in_rmw && !in_zero_idiom) |->
        (out_src2_vld && (out_src2_tag == out_old_tag))); // R4

    AST_WB_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_src0_vld && wb_valid && (wb_tag == out_src0_tag)) |->
        out_src0_rdy); // R8

    AST_NEW_TAG_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_dst_vld) |-> (out_dst_tag != out_old_tag)); // R2
endmodule

bind rr_rename_unit rr_rename_checker #(
    .TAG_W (TAG_W),
    .CNT_W (CNT_W)
) i_rr_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_ready      (in_ready),
    .in_rmw        (in_rmw),
    .in_zero_idiom (in_zero_idiom),
    .in_dst_vld    (in_dst_vld),
    .out_valid     (out_valid),
    .out_src0_vld  (out_src0_vld),
    .out_src0_tag  (out_src0_tag),
    .out_src0_rdy  (out_src0_rdy),
    .out_src1_vld  (out_src1_vld),
    .out_src2_vld  (out_src2_vld),
    .out_src2_tag  (out_src2_tag),
    .out_dst_vld   (out_dst_vld),
    .out_dst_tag   (out_dst_tag),
    .out_dst_rdy   (out_dst_rdy),
    .out_old_tag   (out_old_tag),
    .ret_valid     (ret_valid),
    .ret_old_vld   (ret_old_vld),
    .wb_valid      (wb_valid),
    .wb_tag        (wb_tag),
    .free_cnt      (free_cnt)
);

// File: tb/test_rr_rename_unit.sv
`timescale 1ns/1ps
module test_rr_rename_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_bitcnt_dep = 1'b0;
    logic       in_valid = 1'b0, in_ready;
    logic       in_src0_vld = 1'b0, in_src1_vld = 1'b0, in_dst_vld = 1'b0;
    logic [3:0] in_src0 = '0, in_src1 = '0, in_dst = '0;
    logic       in_rmw = 1'b0, in_zero_idiom = 1'b0, in_bitcount = 1'b0;
    logic       out_valid, out_src0_vld, out_src0_rdy, out_src1_vld, out_src1_rdy;
    logic       out_src2_vld, out_src2_rdy, out_dst_vld, out_dst_rdy;
    logic [7:0] out_src0_tag, out_src1_tag, out_src2_tag, out_dst_tag, out_old_tag;
    logic       ret_valid = 1'b0, ret_old_vld = 1'b0;
    logic [7:0] ret_old_tag = '0;
    logic       wb_valid = 1'b0;
    logic [7:0] wb_tag = '0;

    always #2 clk = ~clk;

    rr_rename_unit i_rr_rename_unit (
        .clk(clk), .rst_n(rst_n), .cfg_bitcnt_dep(cfg_bitcnt_dep),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_src0_vld(in_src0_vld), .in_src0(in_src0),
        .in_src1_vld(in_src1_vld), .in_src1(in_src1),
        .in_dst_vld(in_dst_vld), .in_dst(in_dst),
        .in_rmw(in_rmw), .in_zero_idiom(in_zero_idiom), .in_bitcount(in_bitcount),
        .out_valid(out_valid),
        .out_src0_vld(out_src0_vld), .out_src0_tag(out_src0_tag), .out_src0_rdy(out_src0_rdy),
        .out_src1_vld(out_src1_vld), .out_src1_tag(out_src1_tag), .out_src1_rdy(out_src1_rdy),
        .out_src2_vld(out_src2_vld), .out_src2_tag(out_src2_tag), .out_src2_rdy(out_src2_rdy),
        .out_dst_vld(out_dst_vld), .out_dst_tag(out_dst_tag), .out_dst_rdy(out_dst_rdy),
        .out_old_tag(out_old_tag),
        .ret_valid(ret_valid), .ret_old_vld(ret_old_vld), .ret_old_tag(ret_old_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag)
    );

    int n_chk = 0;
    int n_err = 0;
    int map_m [16];
    bit rdy_m [180];
    int fq [$];
    int pend [$];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_rdy(input int t, input bit wv, input int wt);
        return (rdy_m[t] || (wv && wt == t)) ? 1 : 0;
    endfunction

    // rmode: 0 no retire, 1 retire oldest pending tag, 2 retire without a tag
    task automatic cyc(input string req, input bit v, input bit s0v, input int s0,
                       input bit s1v, input int s1, input bit dv, input int d,
                       input bit rmw, input bit zi, input bit bc,
                       input int rmode, input bit wv, input int wt);
        bit er, fire, e2v, rv;
        int rt, nt;
        rv = (rmode == 1) && (pend.size() > 0);
        rt = rv ? pend[0] : 0;
        @(negedge clk);
        in_valid = v; in_src0_vld = s0v; in_src0 = 4'(s0);
        in_src1_vld = s1v; in_src1 = 4'(s1); in_dst_vld = dv; in_dst = 4'(d);
        in_rmw = rmw; in_zero_idiom = zi; in_bitcount = bc;
        ret_valid = rv || (rmode == 2); ret_old_vld = rv; ret_old_tag = 8'(rt);
        wb_valid = wv; wb_tag = 8'(wt);
        #1;
        er = (fq.size() > 0);
        fire = v && er;
        check({req, " in_ready"}, int'(in_ready), int'(er));
        check({req, " out_valid"}, int'(out_valid), int'(fire));
        if (fire) begin
            check({req, " src0_vld"}, int'(out_src0_vld), int'(s0v && !zi));
            if (s0v && !zi) begin
                check({req, " src0_tag"}, int'(out_src0_tag), map_m[s0]);
                check({req, " src0_rdy"}, int'(out_src0_rdy), exp_rdy(map_m[s0], wv, wt));
            end
            check({req, " src1_vld"}, int'(out_src1_vld), int'(s1v && !zi));
            if (s1v && !zi) begin
                check({req, " src1_tag"}, int'(out_src1_tag), map_m[s1]);
                check({req, " src1_rdy"}, int'(out_src1_rdy), exp_rdy(map_m[s1], wv, wt));
            end
            e2v = dv && !zi && (rmw || (cfg_bitcnt_dep && bc));
            check({req, " src2_vld"}, int'(out_src2_vld), int'(e2v));
            if (e2v) begin
                check({req, " src2_tag"}, int'(out_src2_tag), map_m[d]);
                check({req, " src2_rdy"}, int'(out_src2_rdy), exp_rdy(map_m[d], wv, wt));
            end
            check({req, " dst_vld"}, int'(out_dst_vld), int'(dv));
            if (dv) begin
                check({req, " dst_tag"}, int'(out_dst_tag), fq[0]);
                check({req, " old_tag"}, int'(out_old_tag), map_m[d]);
                check({req, " dst_rdy"}, int'(out_dst_rdy), int'(zi));
            end
        end
        @(posedge clk);
        if (rv) begin
            rdy_m[rt] = 1'b0;
            void'(pend.pop_front());
        end
        if (wv) rdy_m[wt] = 1'b1;
        if (fire && dv) begin
            nt = fq.pop_front();
            pend.push_back(map_m[d]);
            map_m[d] = nt;
            rdy_m[nt] = zi;
        end
        if (rv) fq.push_back(rt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) map_m[i] = i;
        for (int i = 0; i < 180; i++) rdy_m[i] = (i < 16);
        for (int i = 16; i < 180; i++) fq.push_back(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity map, all ready; no destination so nothing allocated (R11)
        for (int r = 0; r < 16; r++)
            cyc("R1", 1, 1, r, 1, 15 - r, 0, 0, 0, 0, 0, 0, 0, 0);
        // R11: retirement with no tag frees nothing; first allocation is tag 16 (R1)
        cyc("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2, 0, 0);
        cyc("R1", 1, 0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0, 0);
        cyc("R3", 1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R8", 1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 1, map_m[3]);
        cyc("R3", 1, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // Sweep over class flags, option, same-name sources, bypass and retirement
        for (int i = 0; i < 256; i++) begin
            bit rmw, zi, bc, wv;
            int d, s0, s1, rm;
            string req;
            rmw = i[0]; bc = i[1]; zi = (i % 5 == 0); wv = i[2] ^ i[3];
            cfg_bitcnt_dep = i[3];
            d  = (i * 7) % 16;
            s0 = (i % 3 == 0) ? d : (i * 5 + 2) % 16;
            s1 = (i * 3 + 1) % 16;
            rm = i[4] ? 1 : 0;
            if (zi)              req = "R5";
            else if (bc && !rmw) req = "R6";
            else if (rmw)        req = "R4";
            else if (s0 == d)    req = "R9";
            else if (wv)         req = "R8";
            else if (rm == 1)    req = "R7";
            else                 req = "R2";
            cyc(req, 1, 1, s0, 1, s1, 1, d, rmw, zi, bc, rm, wv, map_m[s0]);
        end
        cfg_bitcnt_dep = 1'b0;
        cyc("R6", 1, 0, 0, 0, 0, 1, 9, 0, 0, 1, 0, 0, 0);
        cfg_bitcnt_dep = 1'b1;
        cyc("R6", 1, 0, 0, 0, 0, 1, 9, 0, 0, 1, 0, 0, 0);
        cyc("R2", 1, 1, 9, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // Exhaust the free list
        for (int k = 0; fq.size() > 0; k++)
            cyc("R10", 1, 0, 0, 0, 0, 1, k % 16, 0, 0, 0, 0, 0, 0);
        cyc("R10", 1, 1, 4, 0, 0, 1, 4, 0, 0, 0, 0, 0, 0);
        cyc("R10", 1, 1, 4, 0, 0, 1, 4, 0, 0, 0, 1, 0, 0);
        cyc("R10", 1, 1, 4, 0, 0, 1, 4, 0, 0, 0, 0, 0, 0);
        cyc("R10", 1, 1, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // Drain retirements, then reuse returned tags in order
        while (pend.size() > 0)
            cyc("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        for (int k = 0; k < 8; k++)
            cyc("R7", 1, 1, k, 0, 0, 1, k, 0, 0, 0, 0, 0, 0);

        @(negedge clk);
        in_valid = 1'b0; ret_valid = 1'b0; ret_old_vld = 1'b0; wb_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule